// File: doc/BRIEF.md
# Prioritized Supply Switchover Controller

This block is the digital decision core of a three-input power-path selector. Each input channel reports two window-comparator flags (above its undervoltage limit, below its overvoltage limit), a raw gate-off comparator and a raw reverse-blocking comparator. The controller decides which single channel feeds the shared output rail. It raises one gate-enable for that channel and reports each channel's qualification on an active-low validity flag.

Channels are ranked by position, not by voltage. Channel 1 (bit 0) ranks highest. A channel counts as valid only after it has stayed inside its window for an unbroken qualification interval. That interval is a parameterised number of prescaler ticks, so simulation can shrink it.

Every change of channel is a break-before-make handshake. The outgoing gate is dropped and its latched off indication must appear. Then the incoming channel waits until its latched reverse-blocking indication shows the output safely below its supply. Only after that does its gate rise. An enable input and an active-low shutdown input sit over all of this.

Top module: `supply_prio_ctrl`

## Requirements
- R1: Of all valid channels, the one with the lowest bit index (bit 0 = channel 1) is the one connected, regardless of which others are valid.
- R2: A channel becomes valid after exactly TICK_DIV*QUAL_TICKS consecutive clock edges at which both of its window flags are high. A single edge with either flag low clears its progress and drops validity on the next edge.
- R3: valid_n_o[i] is 0 while channel i is valid and 1 otherwise. Out of reset all bits are 1.
- R4: If a lower-ranked channel is connected and a higher-ranked channel becomes valid, the lower one is disconnected and the higher one is then connected.
- R5: If the connected channel loses validity, it is disconnected and the highest-ranked remaining valid channel is then connected.
- R6: After a gate drops, no gate rises until the dropped channel's gate-off comparator has been seen high and latched. That latch clears while its channel's gate is on.
- R7: A channel selected for connection keeps its gate low until its reverse-blocking comparator has been seen high. That indication is latched and cleared once the channel is neither connected nor being connected.
- R8: With en_i low, all gate-enables are low from the next edge. Qualification and valid_n_o keep tracking the window flags.
- R9: With shdn_n_i low, all gate-enables are low and all qualification progress and validity are cleared from the next edge. After release, qualification restarts from zero.
- R10: At most one gate-enable is high in any cycle. Between two different connected channels there is at least one cycle with all gate-enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Connection enable, high to allow a channel to connect |
| shdn_n_i | input | 1 | Active-low shutdown |
| uv_ok_i | input | NCH | Per channel: supply above undervoltage limit |
| ov_ok_i | input | NCH | Per channel: supply below overvoltage limit |
| gate_off_i | input | NCH | Per channel raw comparator: gate has reached its off level |
| rev_ok_i | input | NCH | Per channel raw comparator: output is below the supply by the blocking margin |
| gate_en_o | output | NCH | Per channel gate-enable, at most one high |
| valid_n_o | output | NCH | Per channel active-low validity |

## Verification
The interesting collisions are a preemption or a loss of the connected channel landing while a handshake is still open. Examples are a higher-ranked channel qualifying while the outgoing gate-off latch is held back, and the connected channel dropping out while the next channel's reverse-blocking comparator is held low. The bench holds each comparator low across the decision, then checks that every gate stays low for many cycles and that the correct channel connects once the comparator is released. A continuous monitor judges every cycle for overlapping gates and for a direct hand-over between two channels without an all-off gap.

// File: rtl/supply_prio_pkg.sv
package supply_prio_pkg;

  // Switchover sequencer states
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,  // no gate on, waiting for a candidate
    SW_MAKE  = 2'd1,  // candidate chosen, waiting for reverse-blocking latch
    SW_ON    = 2'd2,  // candidate gate driven
    SW_BREAK = 2'd3   // gate dropped, waiting for gate-off latch
  } sw_state_e;

endpackage

// File: rtl/spc_qual_timer.sv
module spc_qual_timer #(
  parameter int unsigned TICK_DIV   = 16,
  parameter int unsigned QUAL_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_win_i,
  output logic valid_o
);

  localparam int unsigned DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned TICK_W = $clog2(QUAL_TICKS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(QUAL_TICKS - 1);

  logic [DIV_W-1:0]  sub_q,  sub_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              valid_q, valid_d;

  // next-state
  always_comb begin
    sub_d   = sub_q;
    tick_d  = tick_q;
    valid_d = valid_q;
    if (!in_win_i) begin
      sub_d   = '0;
      tick_d  = '0;
      valid_d = 1'b0;
    end else if (!valid_q) begin
      if (sub_q == DIV_LAST) begin
        sub_d = '0;
        if (tick_q == TICK_LAST) begin
          valid_d = 1'b1;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      tick_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sub_q   <= sub_d;
      tick_q  <= tick_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  // R2: any excursion removes validity at the next edge
  a_r2_excursion_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win_i |=> !valid_o);

  // R2: validity only rises after an in-window sample
  a_r2_rise_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(in_win_i));

endmodule

// File: rtl/spc_hs_latch.sv
module spc_hs_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,     // channel gate currently driven
  input  logic arming_i,   // channel currently being connected
  input  logic off_cmp_i,
  input  logic rev_cmp_i,
  output logic off_lat_o,
  output logic rev_lat_o
);

  logic off_q, off_d;
  logic rev_q, rev_d;

  always_comb begin
    off_d = gate_i ? 1'b0 : (off_q | off_cmp_i);
    rev_d = (gate_i | arming_i) ? (rev_q | rev_cmp_i) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b1;   // every gate starts off
      rev_q <= 1'b0;
    end else begin
      off_q <= off_d;
      rev_q <= rev_d;
    end
  end

  assign off_lat_o = off_q;
  assign rev_lat_o = rev_q;

  // R6: the off latch is cleared after a cycle with the gate on
  a_r6_off_clears_on: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i |=> !off_lat_o);

  // R7: the reverse latch is cleared once the channel is idle
  a_r7_rev_clears_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_i || arming_i) |=> !rev_lat_o);

endmodule

// File: rtl/spc_switch_fsm.sv
module spc_switch_fsm
  import supply_prio_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           allow_i,
  input  logic [NCH-1:0] valid_i,
  input  logic [NCH-1:0] off_lat_i,
  input  logic [NCH-1:0] rev_lat_i,
  output logic [NCH-1:0] gate_o,
  output logic [NCH-1:0] arming_o
);

  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  sw_state_e        state_q, state_d;
  logic [CH_W-1:0]  cur_q, cur_d;
  logic [CH_W-1:0]  best;
  logic             best_vld;
  logic [NCH-1:0]   cur_oh;

  // fixed-rank selection: lowest index wins
  always_comb begin
    best     = '0;
    best_vld = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        best     = CH_W'(i);
        best_vld = 1'b1;
      end
    end
  end

  // next-state
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    unique case (state_q)
      SW_IDLE: begin
        if (allow_i && best_vld) begin
          state_d = SW_MAKE;
          cur_d   = best;
        end
      end
      SW_MAKE: begin
        if (!allow_i || !valid_i[cur_q] || (best != cur_q)) begin
          state_d = SW_IDLE;
        end else if (rev_lat_i[cur_q]) begin
          state_d = SW_ON;
        end
      end
      SW_ON: begin
        if (!allow_i || !valid_i[cur_q] || (best != cur_q)) begin
          state_d = SW_BREAK;
        end
      end
      SW_BREAK: begin
        if (off_lat_i[cur_q]) begin
          state_d = SW_IDLE;
        end
      end
      default: state_d = SW_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  assign cur_oh   = NCH'(1) << cur_q;
  assign gate_o   = (state_q == SW_ON)   ? cur_oh : '0;
  assign arming_o = (state_q == SW_MAKE) ? cur_oh : '0;

  // R6: the sequencer holds in break until the off latch is seen
  a_r6_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_BREAK && !off_lat_i[cur_q]) |=> (gate_o == '0));

  // R7: no gate while the reverse-blocking latch is missing
  a_r7_make_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_MAKE && !rev_lat_i[cur_q]) |=> (gate_o == '0));

endmodule

// File: rtl/supply_prio_ctrl.sv
module supply_prio_ctrl #(
  parameter int unsigned NCH        = 3,
  parameter int unsigned TICK_DIV   = 16,
  parameter int unsigned QUAL_TICKS = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           shdn_n_i,
  input  logic [NCH-1:0] uv_ok_i,
  input  logic [NCH-1:0] ov_ok_i,
  input  logic [NCH-1:0] gate_off_i,
  input  logic [NCH-1:0] rev_ok_i,
  output logic [NCH-1:0] gate_en_o,
  output logic [NCH-1:0] valid_n_o
);

  logic [NCH-1:0] in_win;
  logic [NCH-1:0] valid;
  logic [NCH-1:0] off_lat;
  logic [NCH-1:0] rev_lat;
  logic [NCH-1:0] gate;
  logic [NCH-1:0] arming;
  logic           allow;

  assign allow  = en_i & shdn_n_i;
  assign in_win = uv_ok_i & ov_ok_i & {NCH{shdn_n_i}};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    spc_qual_timer #(
      .TICK_DIV   (TICK_DIV),
      .QUAL_TICKS (QUAL_TICKS)
    ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_win_i (in_win[g]),
      .valid_o  (valid[g])
    );

    spc_hs_latch u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_i    (gate[g]),
      .arming_i  (arming[g]),
      .off_cmp_i (gate_off_i[g]),
      .rev_cmp_i (rev_ok_i[g]),
      .off_lat_o (off_lat[g]),
      .rev_lat_o (rev_lat[g])
    );
  end

  spc_switch_fsm #(
    .NCH (NCH)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .allow_i   (allow),
    .valid_i   (valid),
    .off_lat_i (off_lat),
    .rev_lat_i (rev_lat),
    .gate_o    (gate),
    .arming_o  (arming)
  );

  assign gate_en_o = gate;
  assign valid_n_o = ~valid;

  // R10: never two gates at once
  a_r10_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en_o));

  // R10: a driven gate is followed by the same gate or by none
  a_r10_break_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_o != '0) |=> ((gate_en_o == '0) || $stable(gate_en_o)));

  // R8: enable low removes every gate on the next edge
  a_r8_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (gate_en_o == '0));

  // R9: shutdown clears every validity on the next edge
  a_r9_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |=> ((valid_n_o == '1) && (gate_en_o == '0)));

endmodule

// File: tb/supply_prio_ctrl_tb.sv
`timescale 1ns/1ps
module supply_prio_ctrl_tb;

  localparam int NCH = 3;
  localparam int DIV = 2;
  localparam int QT  = 4;
  localparam int NQ  = DIV * QT;

  logic           clk;
  logic           rst_n;
  logic           en;
  logic           shdn_n;
  logic [NCH-1:0] uv_ok;
  logic [NCH-1:0] ov_ok;
  logic [NCH-1:0] off_cmp;
  logic [NCH-1:0] rev_cmp;
  logic [NCH-1:0] gate_en;
  logic [NCH-1:0] valid_n;

  int n_run;
  int n_fail;
  int overlap_err;
  logic [NCH-1:0] prev_gate;

  typedef struct {
    string          tag;
    logic [NCH-1:0] g;
    logic [NCH-1:0] vn;
    logic           chk_g;
  } exp_t;

  exp_t sbq[$];

  supply_prio_ctrl #(
    .NCH        (NCH),
    .TICK_DIV   (DIV),
    .QUAL_TICKS (QT)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .shdn_n_i   (shdn_n),
    .uv_ok_i    (uv_ok),
    .ov_ok_i    (ov_ok),
    .gate_off_i (off_cmp),
    .rev_ok_i   (rev_cmp),
    .gate_en_o  (gate_en),
    .valid_n_o  (valid_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // scoreboard monitor
  initial begin
    exp_t it;
    forever begin
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      n_run++;
      if (valid_n !== it.vn || (it.chk_g && gate_en !== it.g)) begin
        n_fail++;
        $display("FAIL %s: gate=%b valid_n=%b expected gate=%b valid_n=%b",
                 it.tag, gate_en, valid_n, it.g, it.vn);
      end
    end
  end

  // overlap and break-gap monitor (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(gate_en) > 1) overlap_err++;
      if (prev_gate != '0 && gate_en != '0 && gate_en != prev_gate) overlap_err++;
    end
    prev_gate = gate_en;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [NCH-1:0] g,
                            input logic [NCH-1:0] vn);
    exp_t e;
    e.tag = tag; e.g = g; e.vn = vn; e.chk_g = 1'b1;
    sbq.push_back(e);
    #1;
  endtask

  task automatic expect_vn(input string tag, input logic [NCH-1:0] vn);
    exp_t e;
    e.tag = tag; e.g = '0; e.vn = vn; e.chk_g = 1'b0;
    sbq.push_back(e);
    #1;
  endtask

  task automatic win(input int ch, input logic v);
    uv_ok[ch] = v;
    ov_ok[ch] = v;
  endtask

  // watchdog
  initial begin
    #(200000 * 10);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; overlap_err = 0; prev_gate = '0;
    rst_n = 1'b0; en = 1'b1; shdn_n = 1'b1;
    uv_ok = '0; ov_ok = '0; off_cmp = '1; rev_cmp = '1;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out("R3 reset state", 3'b000, 3'b111);

    // qualification of channel 3 alone
    win(2, 1'b1);
    step(NQ - 1);
    expect_vn("R2 not yet qualified", 3'b111);
    step(1);
    expect_vn("R3 channel 3 valid", 3'b011);
    step(6);
    expect_out("R1 sole valid channel connects", 3'b100, 3'b011);

    // glitch on channel 2 restarts its timer
    win(1, 1'b1);
    step(5);
    win(1, 1'b0);
    step(1);
    win(1, 1'b1);
    step(NQ - 1);
    expect_out("R2 glitch restarted timer", 3'b100, 3'b011);
    step(1);
    expect_vn("R2 qualified after restart", 3'b001);
    step(8);
    expect_out("R4 channel 2 preempts channel 3", 3'b010, 3'b001);

    // preemption by channel 1 while channel 2 gate-off is held back
    off_cmp[1] = 1'b0;
    win(0, 1'b1);
    step(NQ);
    expect_vn("R3 all channels valid", 3'b000);
    step(10);
    expect_out("R6 waits for gate-off latch", 3'b000, 3'b000);
    off_cmp[1] = 1'b1;
    step(8);
    expect_out("R1 highest rank connects after break", 3'b001, 3'b000);

    // loss of channel 1 while channel 2 reverse indication is low
    rev_cmp[1] = 1'b0;
    win(0, 1'b0);
    step(1);
    expect_vn("R2 excursion drops validity", 3'b001);
    step(12);
    expect_out("R7 waits for reverse-blocking", 3'b000, 3'b001);
    rev_cmp[1] = 1'b1;
    step(8);
    expect_out("R5 next valid channel connects", 3'b010, 3'b001);

    // enable low
    en = 1'b0;
    step(2);
    expect_out("R8 enable low disconnects", 3'b000, 3'b001);
    win(2, 1'b0);
    step(2);
    expect_out("R8 monitoring continues", 3'b000, 3'b101);
    win(2, 1'b1);
    en = 1'b1;
    step(NQ + 4);
    expect_out("R8 reconnect after enable", 3'b010, 3'b001);

    // shutdown
    shdn_n = 1'b0;
    step(2);
    expect_out("R9 shutdown clears", 3'b000, 3'b111);
    shdn_n = 1'b1;
    step(NQ - 1);
    expect_out("R9 timers restarted", 3'b000, 3'b111);
    step(1);
    expect_vn("R9 requalified", 3'b001);
    step(8);
    expect_out("R1 best channel after shutdown", 3'b010, 3'b001);

    step(2);
    n_run++;
    if (overlap_err != 0) begin
      n_fail++;
      $display("FAIL R10 gate overlap count: actual %0d expected 0", overlap_err);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule